// File: doc/BRIEF.md
# Toggle-Interrupt Free-Running Subcounter

This block is a free-running up-counter that runs on a slow, low-frequency clock. Software picks one bit of the count to watch. When the counter steps and that bit changes value, the block can emit an interrupt pulse. Choosing a low bit gives a fast periodic tick, and choosing a high bit gives a long one. A sticky status flag records each pulse until software clears it.

Counting can be halted by three external conditions: an attached debugger, a halt trigger that can qualify the debugger condition, and the host processor being in deep sleep. Each of these inputs is resynchronised into the counter clock domain before it is used. As a result, pausing and resuming take effect a fixed two cycles after the input changes.

A debugger-run option lets the count keep running while a debugger is attached. In that case the block flags that any reset generation must be held off. A small register port gives access to the configuration word, the sticky status flag and a read-only view of the count.

Top module: `tick_subctr`

## Requirements
- R1: After reset the configuration word, the status flag, the count, `irq_pulse`, `rst_blocked` and `reg_rdata` are all zero, and the first count read after reset returns 0.
- R2: The configuration word at address 0 keeps only these bits: bit 0 (action), bits 20:16 (watched bit index), bit 28 (trigger qualify), bit 30 (sleep pause) and bit 31 (debugger run). All other bits read as zero, so writing all ones reads back 0xD01F0001.
- R3: When not paused, the count at address 2 rises by one on every clock and wraps from all ones to zero. Writes to address 2 have no effect on it.
- R4: With bit 0 set, `irq_pulse` is high for the cycle that follows each clock edge at which the watched count bit changes. Index k fires exactly once per 2^k steps. Index 0 fires on every step. An index at or above the counter width never fires.
- R5: With bit 0 clear, `irq_pulse` stays low for any index.
- R6: Bit 0 of address 1 is a sticky flag that is set by every pulse. Writing 1 to it clears it and writing 0 leaves it unchanged. If a pulse and a clear arrive in the same cycle, the set wins.
- R7: With bits 31 and 28 clear, an attached debugger stops the count.
- R8: With bit 28 set and bit 31 clear, the debugger pauses the count only while `halt_trig` is also high.
- R9: With bit 31 set, the count keeps running while a debugger is attached, and `rst_blocked` is high while the synchronised debugger input is high.
- R10: With bit 30 set, `deep_sleep` pauses the count. With bit 30 clear, `deep_sleep` has no effect.
- R11: A pause input that changes between edges E0 and E1 takes effect from edge E3 onward. The count therefore still advances at edges E1 and E2 when a pause starts, and resumes at edge E3 when a pause ends.
- R12: While paused, the count does not change and no interrupt pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow counter clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 config, 1 status, 2 count |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr`, valid one edge later |
| dbg_attached | input | 1 | Debugger connected (asynchronous) |
| halt_trig | input | 1 | External halt trigger (asynchronous) |
| deep_sleep | input | 1 | Processor in deep sleep (asynchronous) |
| irq_pulse | output | 1 | One-cycle interrupt pulse on a toggle of the watched bit |
| rst_blocked | output | 1 | Reset generation must be held off |

## Verification
The bench builds the block with an 8-bit counter and two synchroniser stages. With this width the wrap from all ones to zero, the once-per-128-steps toggle of the top bit, and an index beyond the counter width can all be reached within a few hundred cycles. The pulse table counts interrupts over a 256-step window, so each entry gives an exact expected count. The two-stage synchroniser makes the pause and resume latency an exact cycle count, and the bench checks that count through the count register.

// File: rtl/tick_subctr_pkg.sv
package tick_subctr_pkg;

  localparam int REG_W   = 32;
  localparam int IDX_W   = 5;
  localparam int ADDR_W  = 2;

  // configuration field positions (software visible)
  localparam int POS_ACT  = 0;
  localparam int POS_IDX  = 16;
  localparam int POS_TQ   = 28;
  localparam int POS_SLP  = 30;
  localparam int POS_DRUN = 31;

  localparam logic [REG_W-1:0] CFG_KEEP =
    (REG_W'(1) << POS_ACT) | (REG_W'((1 << IDX_W) - 1) << POS_IDX) |
    (REG_W'(1) << POS_TQ)  | (REG_W'(1) << POS_SLP) | (REG_W'(1) << POS_DRUN);

  localparam logic [ADDR_W-1:0] A_CFG = 2'd0;
  localparam logic [ADDR_W-1:0] A_STS = 2'd1;
  localparam logic [ADDR_W-1:0] A_CNT = 2'd2;

  typedef struct packed {
    logic             dbg_run;
    logic             slp_pause;
    logic             trig_qual;
    logic [IDX_W-1:0] idx;
    logic             act;
  } cfg_t;

  function automatic cfg_t cfg_unpack(logic [REG_W-1:0] w);
    cfg_t c;
    c.act       = w[POS_ACT];
    c.idx       = w[POS_IDX +: IDX_W];
    c.trig_qual = w[POS_TQ];
    c.slp_pause = w[POS_SLP];
    c.dbg_run   = w[POS_DRUN];
    return c;
  endfunction

endpackage

// File: rtl/tsc_sync.sv
module tsc_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= '0;
    else     chain_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[s] <= '0;
      else     chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/tsc_pause.sv
module tsc_pause
  import tick_subctr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  cfg_t cfg_i,
  input  logic dbg_s_i,
  input  logic trig_s_i,
  input  logic slp_s_i,
  output logic run_o,
  output logic rst_blocked_o
);
  logic dbg_hold, slp_hold;

  always_comb begin
    dbg_hold = dbg_s_i && !cfg_i.dbg_run && (!cfg_i.trig_qual || trig_s_i);
    slp_hold = slp_s_i && cfg_i.slp_pause;
    run_o    = !(dbg_hold || slp_hold);
  end

  always_ff @(posedge clk) begin
    if (rst) rst_blocked_o <= 1'b0;
    else     rst_blocked_o <= dbg_s_i && cfg_i.dbg_run;
  end

  AST_BLOCK_NEEDS_DBG: assert property (@(posedge clk) disable iff (rst)
    rst_blocked_o |-> $past(dbg_s_i)); // R9
  AST_DRUN_KEEPS_RUN: assert property (@(posedge clk) disable iff (rst)
    (cfg_i.dbg_run && !slp_s_i) |-> run_o); // R9
  AST_SLEEP_OFF_RUNS: assert property (@(posedge clk) disable iff (rst)
    (!cfg_i.slp_pause && !dbg_s_i) |-> run_o); // R10
endmodule

// File: rtl/tsc_count.sv
module tsc_count
  import tick_subctr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             act_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_nxt, flips;
  logic             hit;

  always_comb begin
    cnt_nxt = cnt_o + CNT_W'(1);
    flips   = cnt_o ^ cnt_nxt;
    hit     = 1'b0;
    for (int i = 0; i < CNT_W; i++) begin
      if (idx_i == IDX_W'(i)) hit = flips[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
      irq_o <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (run_i) begin
        cnt_o <= cnt_nxt;
        irq_o <= act_i && hit;
      end
    end
  end

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    run_i |=> (cnt_o == $past(cnt_o) + CNT_W'(1))); // R3
  AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> $stable(cnt_o)); // R12
  AST_NO_IRQ_PAUSED: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> !irq_o); // R12
  AST_NO_ACT_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    !act_i |=> !irq_o); // R5
endmodule

// File: rtl/tsc_regs.sv
module tsc_regs
  import tick_subctr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              irq_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output cfg_t              cfg_o,
  output logic [REG_W-1:0]  rdata_o
);
  logic [REG_W-1:0] cfg_raw;
  logic             sts_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_raw <= '0;
      sts_q   <= 1'b0;
    end else begin
      if (wr_i && addr_i == A_CFG) cfg_raw <= wdata_i & CFG_KEEP;
      if (irq_i)                                    sts_q <= 1'b1;
      else if (wr_i && addr_i == A_STS && wdata_i[0]) sts_q <= 1'b0;
    end
  end

  assign cfg_o = cfg_unpack(cfg_raw);

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else begin
      case (addr_i)
        A_CFG:   rdata_o <= cfg_raw;
        A_STS:   rdata_o <= REG_W'(sts_q);
        A_CNT:   rdata_o <= REG_W'(cnt_i);
        default: rdata_o <= '0;
      endcase
    end
  end

  AST_STICKY_SET: assert property (@(posedge clk) disable iff (rst)
    irq_i |=> sts_q); // R6
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr_i && addr_i == A_STS && wdata_i[0] && !irq_i) |=> !sts_q); // R6
  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (addr_i == A_CFG) |=> ((rdata_o & ~CFG_KEEP) == '0)); // R2
endmodule

// File: rtl/tick_subctr.sv
module tick_subctr
  import tick_subctr_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              dbg_attached,
  input  logic              halt_trig,
  input  logic              deep_sleep,
  output logic              irq_pulse,
  output logic              rst_blocked
);
  localparam int N_SYNC = 3;

  cfg_t             cfg;
  logic [N_SYNC-1:0] sync_v;
  logic             run;
  logic [CNT_W-1:0] cnt;

  tsc_sync #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .async_i({deep_sleep, halt_trig, dbg_attached}),
    .sync_o(sync_v)
  );

  tsc_pause u_pause (
    .clk(clk), .rst(rst), .cfg_i(cfg),
    .dbg_s_i(sync_v[0]), .trig_s_i(sync_v[1]), .slp_s_i(sync_v[2]),
    .run_o(run), .rst_blocked_o(rst_blocked)
  );

  tsc_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .run_i(run), .act_i(cfg.act), .idx_i(cfg.idx),
    .cnt_o(cnt), .irq_o(irq_pulse)
  );

  tsc_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_i(reg_wr), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .irq_i(irq_pulse), .cnt_i(cnt),
    .cfg_o(cfg), .rdata_o(reg_rdata)
  );
endmodule

// File: tb/tick_subctr_tb_top.sv
module tick_subctr_tb_top;
  localparam int CW = 8;
  localparam int CMOD = 1 << CW;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dbg_attached = 1'b0, halt_trig = 1'b0, deep_sleep = 1'b0;
  logic        irq_pulse, rst_blocked;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tick_subctr #(.CNT_W(CW), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dbg_attached(dbg_attached), .halt_trig(halt_trig), .deep_sleep(deep_sleep),
    .irq_pulse(irq_pulse), .rst_blocked(rst_blocked)
  );

  // {action[15], index[14:10], expected pulses in 256 steps[9:0]}
  localparam logic [15:0] VEC [7] = '{
    {1'b1, 5'd0, 10'd256}, {1'b1, 5'd1, 10'd128}, {1'b1, 5'd3, 10'd32},
    {1'b1, 5'd5, 10'd8},   {1'b1, 5'd7, 10'd2},   {1'b0, 5'd2, 10'd0},
    {1'b1, 5'd9, 10'd0}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(10 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [31:0] a, b;
    int pulses;
    bit dbl;
    wait_n(3);
    chk(irq_pulse == 0 && rst_blocked == 0 && reg_rdata == 0, "R1 outputs in reset",
        {30'b0, irq_pulse, rst_blocked}, 0);
    rst = 1'b0; reg_addr = 2'd2;
    @(negedge clk);
    chk(reg_rdata == 0, "R1 count after reset", reg_rdata, 0);
    rd(2'd0, a); chk(a == 0, "R1 config after reset", a, 0);
    rd(2'd1, a); chk(a == 0, "R1 status after reset", a, 0);

    // R3 wrap over 300 steps
    rd(2'd2, a); wait_n(300); b = reg_rdata;
    chk(b == 32'((a + 300) % CMOD), "R3 count wraps", b, 32'((a + 300) % CMOD));
    // R3 writes to count ignored
    rd(2'd2, a); wr(2'd2, 32'h55); rd(2'd2, b);
    chk(b == 32'((a + 2) % CMOD), "R3 count write ignored", b, 32'((a + 2) % CMOD));

    // R4 / R5 pulse table
    foreach (VEC[v]) begin
      wr(2'd0, {11'b0, VEC[v][14:10], 15'b0, VEC[v][15]});
      @(negedge clk);
      pulses = 0; dbl = 0;
      for (int i = 0; i < 256; i++) begin
        @(negedge clk);
        if (irq_pulse) pulses++;
      end
      chk(pulses == int'(VEC[v][9:0]), VEC[v][15] ? "R4 pulse count" : "R5 no pulses",
          32'(pulses), 32'(VEC[v][9:0]));
    end
    // R4 single-cycle pulse for index 2
    wr(2'd0, 32'h0002_0001);
    @(negedge clk);
    dbl = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (irq_pulse && i > 0 && a[0]) dbl = 1;
      a[0] = irq_pulse;
    end
    chk(!dbl, "R4 pulse lasts one cycle", 32'(dbl), 0);

    // R6 sticky status
    wr(2'd0, 32'h0);
    rd(2'd1, a); chk(a == 1, "R6 sticky set", a, 1);
    wr(2'd1, 32'h0); rd(2'd1, a); chk(a == 1, "R6 write 0 keeps flag", a, 1);
    wr(2'd1, 32'h1); rd(2'd1, a); chk(a == 0, "R6 write 1 clears", a, 0);

    // R2 reserved bits
    wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, a);
    chk(a == 32'hD01F_0001, "R2 kept bits", a, 32'hD01F_0001);

    // R7 / R11 / R12 debugger pause with interrupts on every step
    wr(2'd0, 32'h0000_0001);
    rd(2'd2, a); dbg_attached = 1'b1;
    wait_n(6); b = reg_rdata;
    chk(b == 32'((a + 3) % CMOD), "R11 pause latency", b, 32'((a + 3) % CMOD));
    pulses = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (irq_pulse) pulses++;
    end
    chk(reg_rdata == b, "R7 debugger pauses", reg_rdata, b);
    chk(pulses == 0, "R12 no irq while paused", 32'(pulses), 0);
    b = reg_rdata; dbg_attached = 1'b0;
    wait_n(3); chk(reg_rdata == b, "R11 resume latency hold", reg_rdata, b);
    wait_n(1); chk(reg_rdata == 32'((b + 1) % CMOD), "R11 resume step", reg_rdata, 32'((b + 1) % CMOD));

    // R8 trigger qualified
    wr(2'd0, 32'h1000_0000);
    dbg_attached = 1'b1; halt_trig = 1'b0;
    rd(2'd2, a); wait_n(10);
    chk(reg_rdata == 32'((a + 10) % CMOD), "R8 runs without trigger", reg_rdata, 32'((a + 10) % CMOD));
    halt_trig = 1'b1; wait_n(5); a = reg_rdata; wait_n(5);
    chk(reg_rdata == a, "R8 pauses with trigger", reg_rdata, a);
    halt_trig = 1'b0;

    // R9 debugger run
    wr(2'd0, 32'h8000_0000);
    wait_n(4);
    chk(rst_blocked == 1'b1, "R9 reset blocked", 32'(rst_blocked), 1);
    rd(2'd2, a); wait_n(10);
    chk(reg_rdata == 32'((a + 10) % CMOD), "R9 counts with debugger", reg_rdata, 32'((a + 10) % CMOD));
    dbg_attached = 1'b0; wait_n(4);
    chk(rst_blocked == 1'b0, "R9 block released", 32'(rst_blocked), 0);

    // R10 deep sleep
    wr(2'd0, 32'h0); deep_sleep = 1'b1;
    rd(2'd2, a); wait_n(10);
    chk(reg_rdata == 32'((a + 10) % CMOD), "R10 sleep ignored when off", reg_rdata, 32'((a + 10) % CMOD));
    wr(2'd0, 32'h4000_0000); wait_n(4); a = reg_rdata; wait_n(6);
    chk(reg_rdata == a, "R10 sleep pauses", reg_rdata, a);
    deep_sleep = 1'b0;

    finish_run();
  end
endmodule